// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns one software write into a control command for a single CPU. The written word holds a two-bit command kind, a five-bit target CPU number and a six-bit vector. Depending on the kind, the block posts an interrupt carrying the vector, requests a reset, requests a halt or requests a resume. Each request is a one-cycle pulse on the bit of a per-CPU output vector that belongs to the target CPU.

The block also tracks which CPUs are halted. A halted CPU stays halted when interrupts are posted to it, and leaves the halted state only through a resume or an accepted reset. An accepted reset is followed one cycle later by a resume pulse to the same CPU, so the CPU is reactivated after it is reset. A reset command is accepted only when its vector equals the power-on reset code, which is a parameter. A reset command with any other vector is dropped and sets a sticky error flag. Commands aimed at CPU numbers at or above the configured CPU count are dropped without any effect.

Top module: `ipi_dispatch`

## Requirements
- R1: The write word is decoded as kind = bits 17:16, target = bits 12:8, vector = bits 5:0. A command's pulses appear in the cycle after the write edge, and a cycle without `cmd_wr` produces no interrupt, reset or halt pulse.
- R2: Kind 0 pulses `irq_post[target]` for one cycle, and `irq_vector` then shows the vector. `irq_vector` keeps its value until the next accepted interrupt.
- R3: Kind 1 with vector equal to `POR_CODE` pulses `rst_req[target]` and clears that CPU's halted flag. In the next cycle it pulses `resume_req[target]`.
- R4: Kind 2 pulses `halt_req[target]` and sets `cpu_halted[target]`. An interrupt posted to a halted CPU leaves `cpu_halted` unchanged.
- R5: Kind 3 pulses `resume_req[target]` and clears `cpu_halted[target]`.
- R6: Kind 1 with any vector other than `POR_CODE` produces no pulse and sets `bad_reset_err`. The flag stays set until reset.
- R7: A command whose target is at or above `NUM_CPU` produces no pulse and changes neither `cpu_halted`, `irq_vector` nor `bad_reset_err`.
- R8: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the dispatch register |
| cmd_data | input | 18 | Written word: kind, target and vector |
| irq_post | output | NUM_CPU | Per-CPU interrupt post pulse |
| irq_vector | output | 6 | Vector of the most recent accepted interrupt |
| rst_req | output | NUM_CPU | Per-CPU reset request pulse |
| halt_req | output | NUM_CPU | Per-CPU halt request pulse |
| resume_req | output | NUM_CPU | Per-CPU resume request pulse |
| cpu_halted | output | NUM_CPU | Per-CPU halted state |
| bad_reset_err | output | 1 | Sticky flag: a reset command carried a wrong code |

## Verification
The assertions assume that `cmd_data` is meaningful only in cycles where `cmd_wr` is high, and that at most one command arrives per cycle. They also assume that the five-bit target field may legally name a CPU that does not exist. The stimulus draws targets from twice the CPU count, so out-of-range commands occur often. It biases reset commands toward the valid code so that both accepted and rejected resets appear, and it inserts idle cycles between writes and back-to-back writes alike.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int          NUM_CPU  = 8,
  parameter logic [5:0]  POR_CODE = 6'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [17:0]        cmd_data,
  output logic [NUM_CPU-1:0] irq_post,
  output logic [5:0]         irq_vector,
  output logic [NUM_CPU-1:0] rst_req,
  output logic [NUM_CPU-1:0] halt_req,
  output logic [NUM_CPU-1:0] resume_req,
  output logic [NUM_CPU-1:0] cpu_halted,
  output logic               bad_reset_err
);
  localparam logic [NUM_CPU-1:0] ONE = NUM_CPU'(1);

  logic [1:0] kind;
  logic [4:0] tgt;
  logic [5:0] vec;
  logic       hit;
  logic       code_ok;
  logic [NUM_CPU-1:0] sel, int_sel, rst_sel, halt_sel, res_sel;

  assign kind    = cmd_data[17:16];
  assign tgt     = cmd_data[12:8];
  assign vec     = cmd_data[5:0];
  assign hit     = cmd_wr && (32'(tgt) < NUM_CPU);
  assign code_ok = (vec == POR_CODE);
  assign sel     = hit ? (ONE << tgt) : '0;

  assign int_sel  = (kind == 2'd0) ? sel : '0;
  assign rst_sel  = (kind == 2'd1 && code_ok) ? sel : '0;
  assign halt_sel = (kind == 2'd2) ? sel : '0;
  assign res_sel  = (kind == 2'd3) ? sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_post      <= '0;
      irq_vector    <= '0;
      rst_req       <= '0;
      halt_req      <= '0;
      resume_req    <= '0;
      cpu_halted    <= '0;
      bad_reset_err <= 1'b0;
    end else begin
      irq_post   <= int_sel;
      rst_req    <= rst_sel;
      halt_req   <= halt_sel;
      resume_req <= res_sel | rst_req;
      cpu_halted <= (cpu_halted | halt_sel) & ~(res_sel | rst_sel);
      if (|int_sel)
        irq_vector <= vec;
      if (hit && kind == 2'd1 && !code_ok)
        bad_reset_err <= 1'b1;
    end
  end
endmodule

module ipi_dispatch_chk #(
  parameter int          NUM_CPU  = 8,
  parameter logic [5:0]  POR_CODE = 6'h01
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_wr,
  input logic [17:0]        cmd_data,
  input logic [NUM_CPU-1:0] irq_post,
  input logic [5:0]         irq_vector,
  input logic [NUM_CPU-1:0] rst_req,
  input logic [NUM_CPU-1:0] halt_req,
  input logic [NUM_CPU-1:0] resume_req,
  input logic [NUM_CPU-1:0] cpu_halted,
  input logic               bad_reset_err
);
  logic out_range, bad_rst;
  assign out_range = cmd_wr && (32'(cmd_data[12:8]) >= NUM_CPU);
  assign bad_rst   = cmd_wr && !out_range && cmd_data[17:16] == 2'd1 &&
                     cmd_data[5:0] != POR_CODE;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (irq_post == '0 && rst_req == '0 && halt_req == '0));

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_post, rst_req, halt_req}));

  assert_reset_then_resume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_req) |=> ((resume_req & $past(rst_req)) == $past(rst_req)));

  assert_halt_sets_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_req) |-> ((cpu_halted & halt_req) == halt_req));

  assert_bad_code_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rst |=> (bad_reset_err && rst_req == '0));

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_reset_err |=> bad_reset_err);

  assert_drop_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_range |=> (irq_post == '0 && rst_req == '0 && halt_req == '0 &&
                   $stable(cpu_halted) && $stable(irq_vector)));
endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CPU(NUM_CPU), .POR_CODE(POR_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
  .irq_post(irq_post), .irq_vector(irq_vector), .rst_req(rst_req),
  .halt_req(halt_req), .resume_req(resume_req), .cpu_halted(cpu_halted),
  .bad_reset_err(bad_reset_err));

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
  localparam int         N   = 8;
  localparam logic [5:0] POR = 6'h01;

  logic clk = 0, rst_n = 0, cmd_wr = 0;
  logic [17:0] cmd_data = '0;
  logic [N-1:0] irq_post, rst_req, halt_req, resume_req, cpu_halted;
  logic [5:0] irq_vector;
  logic bad_reset_err;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] e_irq, e_rst, e_halt, e_res, e_halted;
  logic [5:0]   e_vec;
  logic         e_err;

  always #4 clk = ~clk;

  ipi_dispatch #(.NUM_CPU(N), .POR_CODE(POR)) i_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .irq_post(irq_post), .irq_vector(irq_vector), .rst_req(rst_req),
    .halt_req(halt_req), .resume_req(resume_req), .cpu_halted(cpu_halted),
    .bad_reset_err(bad_reset_err));

  function automatic logic [17:0] word(input int k, input int t, input int v);
    return {2'(k), 3'b0, 5'(t), 2'b0, 6'(v)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 irq_post", 32'(irq_post), 32'(e_irq));
    chk("R2 irq_vector", 32'(irq_vector), 32'(e_vec));
    chk("R3 rst_req", 32'(rst_req), 32'(e_rst));
    chk("R4 halt_req", 32'(halt_req), 32'(e_halt));
    chk("R5 resume_req", 32'(resume_req), 32'(e_res));
    chk("R4 cpu_halted", 32'(cpu_halted), 32'(e_halted));
    chk("R6 bad_reset_err", 32'(bad_reset_err), 32'(e_err));
  endtask

  // Model from R1..R7: compute expected outputs for the edge that samples this write.
  task automatic predict(input logic wr, input logic [17:0] d);
    logic [N-1:0] s, prev_rst;
    int k, t, v;
    k = int'(d[17:16]); t = int'(d[12:8]); v = int'(d[5:0]);
    prev_rst = e_rst;
    s = (wr && t < N) ? (N'(1) << t) : '0;
    e_irq  = (k == 0) ? s : '0;
    e_rst  = (k == 1 && 6'(v) == POR) ? s : '0;
    e_halt = (k == 2) ? s : '0;
    e_res  = ((k == 3) ? s : '0) | prev_rst;
    e_halted = (e_halted | e_halt) & ~(((k == 3) ? s : '0) | e_rst);
    if (|e_irq) e_vec = 6'(v);
    if (|s && k == 1 && 6'(v) != POR) e_err = 1'b1;
  endtask

  task automatic step(input logic wr, input logic [17:0] d);
    cmd_wr = wr; cmd_data = d;
    predict(wr, d);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    e_irq = '0; e_rst = '0; e_halt = '0; e_res = '0; e_halted = '0; e_vec = '0; e_err = 0;
    repeat (3) @(negedge clk);
    check_all();                       // R8 reset state
    rst_n = 1;
    step(0, '0);                       // R1 idle
    step(1, word(0, 3, 6'h2A));        // R2 interrupt
    step(0, word(0, 4, 6'h11));        // R1 data ignored without strobe
    step(1, word(2, 2, 0));            // R4 halt
    step(1, word(0, 2, 6'h05));        // R4 interrupt does not wake
    step(1, word(3, 2, 0));            // R5 resume
    step(1, word(2, 5, 0));            // R4 halt cpu5
    step(1, word(1, 5, POR));          // R3 accepted reset clears halt
    step(0, '0);                       // R3 reactivation pulse
    step(1, word(1, 6, 6'h3F));        // R6 bad code
    step(1, word(0, 8, 6'h07));        // R7 just above range
    step(1, word(2, 31, 0));           // R7 far above range
    step(1, word(1, N - 1, POR));      // R3 top CPU
    step(1, word(1, 0, POR));          // R3 back-to-back resets
    step(0, '0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic wr;
      int k, t, v;
      wr = ($urandom % 4) != 0;
      k  = int'($urandom % 4);
      t  = int'($urandom % (2 * N));
      v  = (($urandom % 2) == 0) ? int'(POR) : int'($urandom % 64);
      step(wr, word(k, t, v));
    end
    rst_n = 0;
    cmd_wr = 0;
    e_irq = '0; e_rst = '0; e_halt = '0; e_res = '0; e_halted = '0; e_vec = '0; e_err = 0;
    @(negedge clk);
    check_all();                       // R8 reset clears sticky error
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule